// File: doc/BRIEF.md
# Flash Thermometer-to-Binary Output Encoder

This block is the digital back end of a flash converter. It receives the raw result of a bank of 255 comparators. Every comparator whose threshold lies below the input level reads 1, so the vector forms a thermometer code. The block turns this code into an 8-bit word whose value equals the number of asserted comparators. Two active-low format controls then select the number format. One flips the top bit of the word and the other flips the seven bits below it. Together they give offset binary, two's complement, inverted two's complement or fully inverted binary.

The clock of the block is the convert strobe. On each rising edge the comparator vector and both format controls are captured together. The encoded and formatted word appears at the output on the following edge, one encode cycle later. Before edge detection, a three-input neighbour majority vote removes single isolated bubbles in the thermometer code. This keeps a stray comparator from causing a large code error.

Top module: `flash_therm_encoder`

## Requirements
- R1: With both format controls high, a valid thermometer input with c asserted bits (bits 0 to c-1 set) yields the output word c in offset binary, bit 7 being the most significant.
- R2: An all-zero comparator vector yields 0x00 and an all-one vector yields 0xFF when no inversion is selected (saturation at both ends of the range).
- R3: Driving msb_inv_n low inverts only bit 7 of the word, which gives two's complement.
- R4: Driving lsb_inv_n low inverts only bits 6 down to 0 of the word.
- R5: Driving both controls low inverts all eight bits (inverted binary). Driving only lsb_inv_n low gives inverted two's complement.
- R6: The word for the inputs sampled on strobe edge k appears on data_out after edge k+1. It does not appear after edge k.
- R7: The format controls are captured on the same edge as the comparator vector, so a format change reaches the output with the same one-cycle latency as the data captured with it.
- R8: data_out changes only at strobe edges. Input changes between edges have no effect until the edges that capture and present them.
- R9: A single isolated bubble is corrected and the intended count is output. A bubble is either a 0 with 1s on both neighbours, or a 1 with 0s on both neighbours, away from the ends of the vector.
- R10: A synchronous active-high reset clears both pipeline stages. data_out is 0x00 after the reset edge and stays 0x00 after the first strobe edge that follows, whatever was applied during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Convert strobe; all capture happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmp_vec | input | 255 | Comparator results, bit i set when threshold i lies below the input |
| msb_inv_n | input | 1 | Active-low control: inverts bit 7 of the output word |
| lsb_inv_n | input | 1 | Active-low control: inverts bits 6..0 of the output word |
| data_out | output | 8 | Registered, formatted conversion word |

## Verification
A new format and a new comparator code can arrive on the same strobe edge. The bench switches both controls and the data together, edge after edge. It then judges each output word against a queue-based model that pairs every sample with the format captured alongside it. A reset can also coincide with a strobe that carries data. The bench applies full-scale data and an active inversion during a reset edge and checks that neither leaks to the output one or two edges later.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;

  // Apply the two active-low field inversions to a binary code.
  function automatic logic [7:0] fmt_word8(input logic [7:0] code,
                                           input logic msb_n,
                                           input logic lsb_n);
    logic [7:0] w;
    w[7]   = code[7] ^ ~msb_n;
    w[6:0] = code[6:0] ^ {7{~lsb_n}};
    return w;
  endfunction

endpackage

// File: rtl/therm_bubble_filter.sv
module therm_bubble_filter #(
  parameter int N_BITS     = 255,
  parameter bit BUBBLE_FIX = 1'b1
) (
  input  logic [N_BITS-1:0] therm_i,
  output logic [N_BITS-1:0] therm_o
);

  generate
    if (BUBBLE_FIX) begin : g_vote
      for (genvar i = 0; i < N_BITS; i++) begin : g_bit
        logic below, above;
        // Virtual neighbours: a 1 below the lowest bit, a 0 above the top bit.
        if (i == 0) begin : g_lo_end
          assign below = 1'b1;
        end else begin : g_lo_mid
          assign below = therm_i[i-1];
        end
        if (i == N_BITS-1) begin : g_hi_end
          assign above = 1'b0;
        end else begin : g_hi_mid
          assign above = therm_i[i+1];
        end
        assign therm_o[i] = (below & therm_i[i]) | (below & above) | (therm_i[i] & above);
      end
    end else begin : g_pass
      assign therm_o = therm_i;
    end
  endgenerate

endmodule

// File: rtl/therm_edge_detect.sv
module therm_edge_detect #(
  parameter int N_BITS = 255
) (
  input  logic [N_BITS-1:0] therm_i,
  output logic [N_BITS-1:0] hot_o
);

  // hot_o[i] marks the top of the run of ones: bit i set, bit i+1 clear.
  generate
    for (genvar i = 0; i < N_BITS; i++) begin : g_edge
      if (i == N_BITS-1) begin : g_top
        assign hot_o[i] = therm_i[i];
      end else begin : g_mid
        assign hot_o[i] = therm_i[i] & ~therm_i[i+1];
      end
    end
  endgenerate

endmodule

// File: rtl/onehot_to_bin.sv
module onehot_to_bin #(
  parameter int CODE_W = 8,
  localparam int N_BITS = (1 << CODE_W) - 1
) (
  input  logic [N_BITS-1:0] hot_i,
  output logic [CODE_W-1:0] code_o
);

  // Position i stands for code i+1; the OR of all selected codes forms the result.
  always_comb begin
    code_o = '0;
    for (int i = 0; i < N_BITS; i++) begin
      code_o = code_o | ({CODE_W{hot_i[i]}} & CODE_W'(i + 1));
    end
  end

endmodule

// File: rtl/flash_therm_encoder.sv
module flash_therm_encoder #(
  parameter bit BUBBLE_FIX = 1'b1,
  localparam int CODE_W = 8,
  localparam int N_CMP  = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CMP-1:0]  cmp_vec,
  input  logic              msb_inv_n,
  input  logic              lsb_inv_n,
  output logic [CODE_W-1:0] data_out
);
  import flash_enc_pkg::*;

  // Stage 1: sample register (comparator vector plus format controls).
  logic [N_CMP-1:0] cmp_q;
  logic             msbn_q, lsbn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      msbn_q <= 1'b1;
      lsbn_q <= 1'b1;
    end else begin
      cmp_q  <= cmp_vec;
      msbn_q <= msb_inv_n;
      lsbn_q <= lsb_inv_n;
    end
  end

  // Encode path between the two stages.
  logic [N_CMP-1:0]  therm_clean;
  logic [N_CMP-1:0]  hot;
  logic [CODE_W-1:0] bin_code;

  therm_bubble_filter #(.N_BITS(N_CMP), .BUBBLE_FIX(BUBBLE_FIX)) u_filter (
    .therm_i (cmp_q),
    .therm_o (therm_clean)
  );

  therm_edge_detect #(.N_BITS(N_CMP)) u_edge (
    .therm_i (therm_clean),
    .hot_o   (hot)
  );

  onehot_to_bin #(.CODE_W(CODE_W)) u_enc (
    .hot_i  (hot),
    .code_o (bin_code)
  );

  // Stage 2: output register.
  always_ff @(posedge clk) begin
    if (rst) data_out <= '0;
    else     data_out <= fmt_word8(bin_code, msbn_q, lsbn_q);
  end

  // R1
  thermo_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    ((cmp_q & (cmp_q + 1'b1)) == '0) |-> $onehot0(hot));

  // R2
  sat_full_chk: assert property (@(posedge clk) disable iff (rst)
    ((&cmp_q) && msbn_q && lsbn_q) |=> (data_out == 8'hFF));

  // R3
  msb_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    (!msbn_q) |=> (data_out[7] == ~$past(bin_code[7])));

  // R4
  lsb_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    (!lsbn_q) |=> (data_out[6:0] == ~$past(bin_code[6:0])));

  // R10
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (data_out == '0 && cmp_q == '0));

endmodule

// File: tb/flash_therm_encoder_bench.sv
module flash_therm_encoder_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [254:0] cmp_vec = '0;
  logic         msb_inv_n = 1'b1;
  logic         lsb_inv_n = 1'b1;
  logic [7:0]   data_out;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  flash_therm_encoder u_flash_therm_encoder (
    .clk       (clk),
    .rst       (rst),
    .cmp_vec   (cmp_vec),
    .msb_inv_n (msb_inv_n),
    .lsb_inv_n (lsb_inv_n),
    .data_out  (data_out)
  );

  function automatic logic [254:0] therm(input int c);
    logic [254:0] v = '0;
    for (int i = 0; i < c; i++) v[i] = 1'b1;
    return v;
  endfunction

  // Behavioural format: offset binary, then field flips by integer xor.
  function automatic logic [7:0] model(input int c, input logic m, input logic l);
    int w = c;
    if (!m) w = w ^ 128;
    if (!l) w = w ^ 127;
    return w[7:0];
  endfunction

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, expv);
    end
  endtask

  // Called at a falling edge; drives one strobe's worth of inputs.
  task automatic apply(input logic [254:0] v, input logic m, input logic l,
                       input int cnt, input string tag);
    logic [7:0] held, e;
    string t;
    cmp_vec   = v;
    msb_inv_n = m;
    lsb_inv_n = l;
    exp_q.push_back(model(cnt, m, l));
    tag_q.push_back(tag);
    held = data_out;
    #5;
    check(data_out == held, "R8 output held between strobes", data_out, held);
    @(posedge clk);
    @(negedge clk);
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    check(data_out == e, t, data_out, e);
  endtask

  task automatic do_reset();
    rst       = 1'b1;
    cmp_vec   = '1;
    msb_inv_n = 1'b0;
    lsb_inv_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(data_out == 8'h00, "R10 output cleared by reset", data_out, 8'h00);
    exp_q.delete();
    tag_q.delete();
    exp_q.push_back(8'h00);
    tag_q.push_back("R10 sample stage cleared by reset");
  endtask

  initial begin
    #(100000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [254:0] v;
    @(posedge clk);
    do_reset();

    // R1 / R6: every count in offset binary, one new value per strobe
    for (int c = 0; c < 256; c++) apply(therm(c), 1'b1, 1'b1, c, "R1 R6 offset binary count");

    // R2: saturation ends
    apply('0, 1'b1, 1'b1, 0,   "R2 all zeros");
    apply('1, 1'b1, 1'b1, 255, "R2 all ones");
    apply('0, 1'b1, 1'b1, 0,   "R2 all zeros after full scale");

    // R3, R4, R5 with R7: format and data change on the same edge
    for (int k = 0; k < 4; k++) begin
      apply(therm(0),   k[0], k[1], 0,   "R3 R4 R5 R7 format at zero");
      apply(therm(127), k[1], k[0], 127, "R3 R4 R5 R7 format at 127");
      apply(therm(128), k[0], k[1], 128, "R3 R4 R5 R7 format at 128");
      apply(therm(129), !k[0], k[1], 129, "R3 R4 R5 R7 format at 129");
      apply(therm(255), k[1], !k[0], 255, "R3 R4 R5 R7 format at 255");
    end
    apply(therm(200), 1'b0, 1'b1, 200, "R3 two's complement 200");
    apply(therm(40),  1'b1, 1'b0, 40,  "R4 low field inverted 40");
    apply(therm(90),  1'b0, 1'b0, 90,  "R5 inverted binary 90");
    apply(therm(90),  1'b1, 1'b0, 90,  "R5 inverted two's complement 90");

    // R9: isolated bubbles
    v = therm(100); v[50] = 1'b0;
    apply(v, 1'b1, 1'b1, 100, "R9 hole inside ones");
    v = therm(100); v[200] = 1'b1;
    apply(v, 1'b1, 1'b1, 100, "R9 stray one above");
    v = therm(200); v[3] = 1'b0;
    apply(v, 1'b0, 1'b1, 200, "R9 hole low with format");
    v = therm(10); v[12] = 1'b1;
    apply(v, 1'b1, 1'b1, 10, "R9 stray one near edge");

    // R10: reset in the middle of traffic
    apply(therm(77), 1'b0, 1'b1, 77, "R6 before reset");
    do_reset();
    apply(therm(33), 1'b1, 1'b1, 33, "R10 first sample after reset");
    apply('0, 1'b1, 1'b1, 0, "R6 flush");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule